// File: doc/BRIEF.md
# Interrupt Source PQ State Controller

This block keeps a two-bit event state for each of `NUM_SRC` interrupt sources. It moves each state on hardware trigger pulses and on 8-byte loads and stores from a simple request/response port. A state is made of a pending bit P and a queued bit Q. A trigger that finds a source idle, or an end-of-interrupt (EOI) that finds a second event queued, raises a notify request. The request carries the source number and goes to a downstream routing engine.

Each source owns one page of address space, or a pair of pages. The address bits above the page give the source number. The low twelve bits of the offset give the operation. In paired mode the even page of each pair accepts trigger stores only, and the odd page holds every operation. Loads have side effects: an EOI load returns whether a new notify was due, and the set-state loads return the old state while they write a new one. When the notify request is not taken, the block holds it and stalls the bus so that no event is lost. Hardware trigger pulses wait in a pending vector and are served one per free cycle, with bus accesses taking priority.

Top module: `pq_event_source`

## Requirements
- R1: State is {P,Q} with 00 idle, 10 pending, 11 queued and 01 off. After reset every source reads 01.
- R2: A trigger moves 00 to 10 and issues a notify. It moves 10 to 11. It leaves 11 and 01 unchanged. Only the 00 case notifies.
- R3: An EOI moves 10 to 00 and 11 to 10, and leaves 00 and 01 unchanged. A load EOI returns 1 only when it started from 11, and 0 otherwise.
- R4: An EOI that starts from 11 issues a notify for that source, whether it came from a load or from a store.
- R5: The source number is the address shifted right by PAGE_BITS+TWO_PAGE. With TWO_PAGE=1, address bit PAGE_BITS set selects the management page. An access changes only the source it addresses.
- R6: Loads at page offsets 0x000-0x7FF perform an EOI. Loads at 0x800-0xBFF return the state. Loads at 0xC00-0xFFF return the old state and write offset bits [9:8] as the new state.
- R7: Stores at 0x000-0x3FF trigger. Stores at 0xC00-0xFFF write offset bits [9:8] as the state. Stores at 0x800-0xBFF change nothing and raise no error.
- R8: A store at 0x400-0x7FF performs an EOI only while `cap_store_eoi` is 1. Otherwise the store is ignored and `err_pulse` rises.
- R9: In paired mode, a load to the even page returns all ones and raises `err_pulse`. A non-trigger store to the even page is ignored and raises `err_pulse`.
- R10: An access whose size is not 8 bytes, or whose source number is NUM_SRC or above, raises `err_pulse`. As a load it returns all ones. As a store it changes nothing.
- R11: Load data is the result value in big-endian byte order, so a result of 1 appears as 64'h0100_0000_0000_0000. `rsp_valid` pulses one cycle after each accepted load and never after a store.
- R12: `ntf_valid` and `ntf_src` hold until `ntf_ready`. While a notify waits unaccepted, `req_ready` is low.
- R13: A hardware trigger and a bus access to the same source in the same cycle are both applied, the bus access first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_store_eoi | input | 1 | Enables EOI by store |
| hw_trig | input | NUM_SRC | Per-source trigger pulses |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 4 | Access size in bytes |
| rsp_valid | output | 1 | Load data valid |
| rsp_rdata | output | 64 | Load data, big-endian |
| ntf_valid | output | 1 | Notify request valid |
| ntf_ready | input | 1 | Notify request taken |
| ntf_src | output | SRC_W | Source to notify |
| err_pulse | output | 1 | Invalid access seen (one cycle) |

## Verification
Two things can meet in one cycle. A bus access to a source can coincide with a hardware trigger pulse on that same source. Separately, a waiting notify can be released in the same cycle that a stalled bus request goes through. The bench provokes the first case by driving a state-set-to-queued store together with a trigger pulse on that source. The order is judged from the result: no notify may appear and the state must read queued, whereas the reverse order would have notified. For the second case the bench holds `ntf_ready` low with a load waiting. It confirms that `req_ready` stays low and the notify stays stable, then raises ready and checks that the load completes in the cycle the handshake does.

// File: rtl/pqsrc_pkg.sv
package pqsrc_pkg;

  typedef enum logic [2:0] {OP_NONE, OP_TRIG, OP_EOI, OP_GET, OP_SET} pq_op_e;

  localparam logic [1:0] PQ_IDLE   = 2'b00;
  localparam logic [1:0] PQ_OFF    = 2'b01;
  localparam logic [1:0] PQ_PEND   = 2'b10;
  localparam logic [1:0] PQ_QUEUED = 2'b11;

  // Returns {notify, next_state}
  function automatic logic [2:0] pq_after_trigger(input logic [1:0] cur);
    case (cur)
      PQ_IDLE:   return {1'b1, PQ_PEND};
      PQ_PEND:   return {1'b0, PQ_QUEUED};
      default:   return {1'b0, cur};
    endcase
  endfunction

  // Returns {notify, next_state}
  function automatic logic [2:0] pq_after_eoi(input logic [1:0] cur);
    case (cur)
      PQ_QUEUED: return {1'b1, PQ_PEND};
      PQ_PEND:   return {1'b0, PQ_IDLE};
      default:   return {1'b0, cur};
    endcase
  endfunction

  function automatic logic [63:0] bswap64(input logic [63:0] v);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[8*b +: 8] = v[8*(7-b) +: 8];
    return r;
  endfunction

endpackage

// File: rtl/pqsrc_bus_decode.sv
module pqsrc_bus_decode import pqsrc_pkg::*; #(
  parameter int NUM_SRC   = 16,
  parameter int PAGE_BITS = 12,
  parameter int TWO_PAGE  = 1,
  parameter int ADDR_W    = 20,
  localparam int SRC_W    = $clog2(NUM_SRC),
  localparam int SHIFT    = PAGE_BITS + TWO_PAGE
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [3:0]        size,
  input  logic              cap_store_eoi,
  output pq_op_e            op,
  output logic [SRC_W-1:0]  src,
  output logic [1:0]        set_val,
  output logic              bad,
  output logic              ones
);
  logic [ADDR_W-1:0] full_src;
  logic [11:0]       off;
  logic              in_range, trig_page;
  logic [1:0]        zone;

  assign full_src  = addr >> SHIFT;
  assign off       = addr[11:0];
  assign src       = full_src[SRC_W-1:0];
  assign in_range  = full_src < ADDR_W'(NUM_SRC);
  assign trig_page = (TWO_PAGE != 0) && !addr[PAGE_BITS];
  assign set_val   = off[9:8];

  always_comb begin
    if (off < 12'h400)      zone = 2'd0;
    else if (off < 12'h800) zone = 2'd1;
    else if (off < 12'hC00) zone = 2'd2;
    else                    zone = 2'd3;
  end

  always_comb begin
    op   = OP_NONE;
    bad  = 1'b0;
    ones = 1'b0;
    if (size != 4'd8 || !in_range) begin
      bad  = 1'b1;
      ones = !write;
    end else if (!write) begin
      if (trig_page) begin
        bad  = 1'b1;
        ones = 1'b1;
      end else begin
        case (zone)
          2'd0, 2'd1: op = OP_EOI;
          2'd2:       op = OP_GET;
          default:    op = OP_SET;
        endcase
      end
    end else begin
      case (zone)
        2'd0: op = OP_TRIG;
        2'd1: begin
          if (trig_page || !cap_store_eoi) bad = 1'b1;
          else op = OP_EOI;
        end
        2'd2: bad = trig_page;
        default: begin
          if (trig_page) bad = 1'b1;
          else op = OP_SET;
        end
      endcase
    end
  end
endmodule

// File: rtl/pqsrc_trig_arb.sv
module pqsrc_trig_arb #(
  parameter int NUM_SRC = 16,
  localparam int SRC_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] hw_trig,
  input  logic               take,
  output logic               pick_valid,
  output logic [SRC_W-1:0]   pick_src
);
  logic [NUM_SRC-1:0] pend_q, clr;

  always_comb begin
    pick_src = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pend_q[i]) pick_src = SRC_W'(i);
  end

  assign pick_valid = |pend_q;

  always_comb begin
    clr = '0;
    if (take) clr[pick_src] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr) | hw_trig;
  end
endmodule

// File: rtl/pq_event_source.sv
module pq_event_source import pqsrc_pkg::*; #(
  parameter int NUM_SRC   = 16,
  parameter int PAGE_BITS = 12,
  parameter int TWO_PAGE  = 1,
  parameter int ADDR_W    = 20,
  localparam int SRC_W    = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cap_store_eoi,
  input  logic [NUM_SRC-1:0] hw_trig,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [3:0]         req_size,
  output logic               rsp_valid,
  output logic [63:0]        rsp_rdata,
  output logic               ntf_valid,
  input  logic               ntf_ready,
  output logic [SRC_W-1:0]   ntf_src,
  output logic               err_pulse
);
  logic             slot_free, bus_fire, hw_fire;
  pq_op_e           dec_op, act_op;
  logic [SRC_W-1:0] dec_src, arb_src, act_src;
  logic [1:0]       dec_setv, pq_old, pq_new;
  logic             dec_bad, dec_ones, arb_valid;
  logic             act_notify, act_update;
  logic [2:0]       tr_trig, tr_eoi;
  logic [63:0]      rval;
  logic [1:0]       pq_q [NUM_SRC];

  pqsrc_bus_decode #(.NUM_SRC(NUM_SRC), .PAGE_BITS(PAGE_BITS),
                     .TWO_PAGE(TWO_PAGE), .ADDR_W(ADDR_W)) dec_i (
    .addr(req_addr), .write(req_write), .size(req_size),
    .cap_store_eoi(cap_store_eoi), .op(dec_op), .src(dec_src),
    .set_val(dec_setv), .bad(dec_bad), .ones(dec_ones));

  pqsrc_trig_arb #(.NUM_SRC(NUM_SRC)) arb_i (
    .clk(clk), .rst_n(rst_n), .hw_trig(hw_trig), .take(hw_fire),
    .pick_valid(arb_valid), .pick_src(arb_src));

  // One state action per cycle; bus before hardware triggers
  assign slot_free = !ntf_valid || ntf_ready;
  assign req_ready = slot_free;
  assign bus_fire  = req_valid && slot_free;
  assign hw_fire   = !bus_fire && slot_free && arb_valid;

  always_comb begin
    act_op  = OP_NONE;
    act_src = arb_src;
    if (bus_fire) begin
      act_op  = dec_op;
      act_src = dec_src;
    end else if (hw_fire) begin
      act_op = OP_TRIG;
    end
  end

  assign pq_old  = (int'(act_src) < NUM_SRC) ? pq_q[act_src] : PQ_OFF;
  assign tr_trig = pq_after_trigger(pq_old);
  assign tr_eoi  = pq_after_eoi(pq_old);

  always_comb begin
    pq_new     = pq_old;
    act_notify = 1'b0;
    act_update = 1'b0;
    case (act_op)
      OP_TRIG: begin pq_new = tr_trig[1:0]; act_notify = tr_trig[2]; act_update = 1'b1; end
      OP_EOI:  begin pq_new = tr_eoi[1:0];  act_notify = tr_eoi[2];  act_update = 1'b1; end
      OP_SET:  begin pq_new = dec_setv; act_update = 1'b1; end
      default: ;
    endcase
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_state
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pq_q[g] <= PQ_OFF;
      else if (act_update && act_src == SRC_W'(g)) pq_q[g] <= pq_new;
    end
  end

  always_comb begin
    rval = '0;
    if (dec_ones) rval = '1;
    else case (dec_op)
      OP_EOI:         rval = {63'b0, act_notify};
      OP_GET, OP_SET: rval = {62'b0, pq_old};
      default:        rval = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ntf_valid <= 1'b0;
      ntf_src   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err_pulse <= 1'b0;
    end else begin
      if (act_notify) begin
        ntf_valid <= 1'b1;
        ntf_src   <= act_src;
      end else if (ntf_ready) begin
        ntf_valid <= 1'b0;
      end
      rsp_valid <= bus_fire && !req_write;
      if (bus_fire && !req_write) rsp_rdata <= bswap64(rval);
      err_pulse <= bus_fire && dec_bad;
    end
  end
endmodule

// File: rtl/pqsrc_checker.sv
module pqsrc_checker #(
  parameter int SRC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_write,
  input logic             rsp_valid,
  input logic             ntf_valid,
  input logic             ntf_ready,
  input logic [SRC_W-1:0] ntf_src,
  input logic             err_pulse,
  input logic             act_notify
);
  assert_ntf_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready) |=> (ntf_valid && $stable(ntf_src)));

  assert_bus_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ntf_valid && !ntf_ready) |-> !req_ready);

  assert_rsp_after_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && req_ready && !req_write));

  assert_err_after_access_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(req_valid && req_ready));

  assert_ntf_from_action_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ntf_valid) |-> $past(act_notify));
endmodule

bind pq_event_source pqsrc_checker #(.SRC_W(SRC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_write(req_write), .rsp_valid(rsp_valid), .ntf_valid(ntf_valid),
  .ntf_ready(ntf_ready), .ntf_src(ntf_src), .err_pulse(err_pulse),
  .act_notify(act_notify));

// File: tb/pq_event_source_tb.sv
`timescale 1ns/1ps
module pq_event_source_tb_top;
  localparam int N = 16;
  localparam int AW = 20;

  logic clk = 1'b0, rst_n = 1'b0, cap = 1'b1;
  logic [N-1:0] hw_trig = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0] req_size = 4'd8;
  logic req_ready, rsp_valid, ntf_valid, err_pulse;
  logic ntf_ready = 1'b1;
  logic [63:0] rsp_rdata;
  logic [3:0] ntf_src;

  int errors = 0, checks = 0, ntf_cnt = 0;
  logic [3:0] ntf_last = '0;

  always #2 clk = ~clk;

  pq_event_source dut_i (
    .clk(clk), .rst_n(rst_n), .cap_store_eoi(cap), .hw_trig(hw_trig),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ntf_valid(ntf_valid), .ntf_ready(ntf_ready),
    .ntf_src(ntf_src), .err_pulse(err_pulse));

  always @(negedge clk) if (rst_n && ntf_valid && ntf_ready) begin
    ntf_cnt  <= ntf_cnt + 1;
    ntf_last <= ntf_src;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int src, input bit mg, input logic [11:0] off);
    return AW'((src << 13) | (int'(mg) << 12) | int'(off));
  endfunction

  // Big-endian image of a small result value: value sits in the top byte
  function automatic logic [63:0] be(input logic [7:0] v);
    return {v, 56'h0};
  endfunction

  task automatic do_op(input logic wr, input logic [AW-1:0] a, input logic [3:0] sz,
                       output logic [63:0] rd, output logic rv, output logic nv,
                       output logic [3:0] ns, output logic er);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_size = 4'd8;
    rd = rsp_rdata; rv = rsp_valid; nv = ntf_valid; ns = ntf_src; er = err_pulse;
  endtask

  task automatic get_pq(input int src, input string tag, input logic [1:0] exp);
    logic [63:0] rd; logic rv, nv, er; logic [3:0] ns;
    do_op(1'b0, mk(src, 1'b1, 12'h800), 4'd8, rd, rv, nv, ns, er);
    chk(tag, rd, be({6'b0, exp}));
  endtask

  // {wr, src[4:0], mg, off[11:0], expv[1:0], ones, ntf, err}
  localparam int NV = 25;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 5'd3, 1'b1, 12'h800, 2'd1, 1'b0, 1'b0, 1'b0}, // R1 reset off
    {1'b0, 5'd3, 1'b1, 12'hC00, 2'd1, 1'b0, 1'b0, 1'b0}, // R6 set 00
    {1'b1, 5'd3, 1'b0, 12'h000, 2'd0, 1'b0, 1'b1, 1'b0}, // R2 00->10 notify
    {1'b1, 5'd3, 1'b0, 12'h000, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 10->11
    {1'b1, 5'd3, 1'b0, 12'h100, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 11 stays
    {1'b0, 5'd3, 1'b1, 12'h800, 2'd3, 1'b0, 1'b0, 1'b0}, // R6 get
    {1'b0, 5'd3, 1'b1, 12'h000, 2'd1, 1'b0, 1'b1, 1'b0}, // R4 load EOI 11
    {1'b0, 5'd3, 1'b1, 12'h000, 2'd0, 1'b0, 1'b0, 1'b0}, // R3 10->00
    {1'b0, 5'd3, 1'b1, 12'h300, 2'd0, 1'b0, 1'b0, 1'b0}, // R3 00 stays
    {1'b0, 5'd3, 1'b1, 12'hF00, 2'd0, 1'b0, 1'b0, 1'b0}, // R6 set 11
    {1'b1, 5'd3, 1'b1, 12'h400, 2'd0, 1'b0, 1'b1, 1'b0}, // R4 store EOI 11
    {1'b1, 5'd3, 1'b1, 12'h500, 2'd0, 1'b0, 1'b0, 1'b0}, // R8 store EOI 10
    {1'b1, 5'd3, 1'b1, 12'hD00, 2'd0, 1'b0, 1'b0, 1'b0}, // R7 set 01
    {1'b1, 5'd3, 1'b1, 12'h000, 2'd0, 1'b0, 1'b0, 1'b0}, // R2 off stays
    {1'b0, 5'd3, 1'b1, 12'h700, 2'd0, 1'b0, 1'b0, 1'b0}, // R3 EOI on off
    {1'b0, 5'd3, 1'b1, 12'h800, 2'd1, 1'b0, 1'b0, 1'b0}, // R3 still off
    {1'b1, 5'd3, 1'b1, 12'hE00, 2'd0, 1'b0, 1'b0, 1'b0}, // R7 set 10
    {1'b1, 5'd3, 1'b1, 12'h900, 2'd0, 1'b0, 1'b0, 1'b0}, // R7 no effect
    {1'b0, 5'd3, 1'b1, 12'hA00, 2'd2, 1'b0, 1'b0, 1'b0}, // R7 unchanged
    {1'b0, 5'd3, 1'b0, 12'h800, 2'd0, 1'b1, 1'b0, 1'b1}, // R9 load trig page
    {1'b1, 5'd3, 1'b0, 12'h400, 2'd0, 1'b0, 1'b0, 1'b1}, // R9 EOI on trig page
    {1'b1, 5'd3, 1'b0, 12'hC00, 2'd0, 1'b0, 1'b0, 1'b1}, // R9 set on trig page
    {1'b0, 5'd3, 1'b1, 12'hB00, 2'd2, 1'b0, 1'b0, 1'b0}, // R9 unchanged
    {1'b0, 5'd5, 1'b1, 12'hC00, 2'd1, 1'b0, 1'b0, 1'b0}, // R5 other source off
    {1'b0, 5'd3, 1'b1, 12'h800, 2'd2, 1'b0, 1'b0, 1'b0}  // R5 source 3 kept
  };

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] rd; logic rv, nv, er; logic [3:0] ns;
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ntf_valid", ntf_valid, 0);
    chk("R12 reset req_ready", req_ready, 1);
    get_pq(0, "R1 source 0 off", 2'b01);
    get_pq(15, "R1 source 15 off", 2'b01);

    // Vector walk
    for (int i = 0; i < NV; i++) begin
      logic [23:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("vec %0d", i);
      do_op(v[23], mk(int'(v[22:18]), v[17], v[16:5]), 4'd8, rd, rv, nv, ns, er);
      if (!v[23]) begin
        chk({tag, " R11 rsp_valid"}, rv, 1);
        chk({tag, " R6 data"}, rd, v[2] ? 64'hFFFF_FFFF_FFFF_FFFF : be({6'b0, v[4:3]}));
      end else begin
        chk({tag, " R11 no rsp on store"}, rv, 0);
      end
      chk({tag, " R2 notify"}, nv, v[1]);
      if (v[1]) chk({tag, " R4 notify src"}, ns, v[21:18]);
      chk({tag, " R10 err"}, er, v[0]);
    end

    // R11 raw big-endian layout
    do_op(1'b0, mk(0, 1'b1, 12'h800), 4'd8, rd, rv, nv, ns, er);
    chk("R11 raw layout", rd, 64'h0100_0000_0000_0000);

    // R8 store EOI with capability clear
    do_op(1'b0, mk(2, 1'b1, 12'hF00), 4'd8, rd, rv, nv, ns, er);
    cap = 1'b0;
    do_op(1'b1, mk(2, 1'b1, 12'h400), 4'd8, rd, rv, nv, ns, er);
    chk("R8 err when disabled", er, 1);
    chk("R8 no notify when disabled", nv, 0);
    get_pq(2, "R8 state kept", 2'b11);
    cap = 1'b1;

    // R10 bad size and out-of-range source
    do_op(1'b0, mk(4, 1'b1, 12'h800), 4'd4, rd, rv, nv, ns, er);
    chk("R10 bad size load data", rd, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R10 bad size err", er, 1);
    do_op(1'b1, mk(4, 1'b1, 12'hC00), 4'd4, rd, rv, nv, ns, er);
    chk("R10 bad size store err", er, 1);
    get_pq(4, "R10 bad size store ignored", 2'b01);
    do_op(1'b0, mk(16, 1'b1, 12'h800), 4'd8, rd, rv, nv, ns, er);
    chk("R10 range load data", rd, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R10 range load err", er, 1);
    do_op(1'b1, mk(16, 1'b1, 12'hC00), 4'd8, rd, rv, nv, ns, er);
    chk("R10 range store err", er, 1);
    get_pq(0, "R10 range store ignored", 2'b01);

    // R12 notify stall
    do_op(1'b0, mk(7, 1'b1, 12'hC00), 4'd8, rd, rv, nv, ns, er);
    ntf_ready = 1'b0;
    do_op(1'b1, mk(7, 1'b0, 12'h000), 4'd8, rd, rv, nv, ns, er);
    chk("R12 notify raised", nv, 1);
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk(7, 1'b1, 12'h800);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R12 req_ready low", req_ready, 0);
      chk("R12 notify held", ntf_valid, 1);
      chk("R12 notify src held", ntf_src, 4'd7);
      chk("R12 no rsp while stalled", rsp_valid, 0);
    end
    ntf_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R12 load completes with release", rsp_valid, 1);
    chk("R12 load data", rsp_rdata, be(8'd2));

    // R2 hardware trigger alone
    do_op(1'b0, mk(10, 1'b1, 12'hC00), 4'd8, rd, rv, nv, ns, er);
    c0 = ntf_cnt;
    @(negedge clk); hw_trig[10] = 1'b1;
    @(negedge clk); hw_trig[10] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 hw trigger notifies", ntf_cnt - c0, 1);
    chk("R2 hw trigger src", ntf_last, 4'd10);
    get_pq(10, "R2 hw trigger state", 2'b10);

    // R13 bus and hardware trigger on the same source, same cycle
    do_op(1'b0, mk(9, 1'b1, 12'hC00), 4'd8, rd, rv, nv, ns, er);
    c0 = ntf_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = mk(9, 1'b1, 12'hF00);
    hw_trig[9] = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; hw_trig[9] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R13 bus first, no notify", ntf_cnt - c0, 0);
    get_pq(9, "R13 bus first, state queued", 2'b11);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule